// File: doc/BRIEF.md
# CPU Clock Prescaler with Clock Output

This block runs on the oscillator clock and produces a one-cycle clock enable for the CPU. In normal mode the enable fires on every second oscillator cycle. In slow mode a two-bit rate code selects a longer period. All periods are powers of two and come from one shared free-running phase counter.

The same counter drives an optional clock output at half the oscillator rate, meant for a port pin. While the chip is in active-halt, the output is held low. A separate pin-mux select tells the port logic that the pin is owned by the clock output. It follows the enable bit even during active-halt.

A new period does not take effect immediately. The block waits for a counter phase where both the old and the new period end together. This way every enable interval is exactly one full old period or one full new period.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: While `rstN` is low, `cpuEn`, `clkOut` and `pinMuxSel` are 0, and the active period is 2 cycles.
- R2: Let t be the number of rising clock edges since `rstN` went high, modulo 32. `cpuEn` is high in the cycle after edge t exactly when t mod N equals N-1, where N is the active period.
- R3: With `slowSel` = 0 the requested period is 2, whatever value `rateCode` holds.
- R4: With `slowSel` = 1 the requested period depends on `rateCode`: 2'b00 gives 4, 2'b10 gives 8, 2'b01 gives 16 and 2'b11 gives 32.
- R5: The active period takes the requested value only at an edge where t mod M equals M-1, with M the larger of the old and new period. Every interval between `cpuEn` pulses therefore equals the old or the new period.
- R6: If `clkOutEn` = 1 and `haltActive` = 0 at edge t, then after that edge `clkOut` equals t mod 2. This is a square wave at half the clock rate.
- R7: If `haltActive` = 1 or `clkOutEn` = 0 at an edge, then after that edge `clkOut` is 0. `haltActive` has no effect on `cpuEn`.
- R8: After each edge, `pinMuxSel` equals the value `clkOutEn` had at that edge, whatever the state of `haltActive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowSel | input | 1 | 1 selects slow mode |
| rateCode | input | 2 | Slow-mode period code |
| clkOutEn | input | 1 | Enables the half-rate clock output |
| haltActive | input | 1 | High while in active-halt |
| cpuEn | output | 1 | One-cycle CPU clock enable |
| clkOut | output | 1 | Half-rate clock for the pin |
| pinMuxSel | output | 1 | Hands the pin to the clock output |

## Verification
The hardest case is a period change that has to wait. The request arrives partway through a long period, or it asks for a longer period whose boundary does not line up with the current counter phase. To reach it, the stimulus walks through every ordered pair of the five period settings. The second setting is applied at several different counter phases. The bench keeps its own count of edges and its own active period, so it can predict the exact edge where the switch happens.

// File: rtl/cpu_presc_pkg.sv
package cpu_presc_pkg;

  // Width of a period exponent; bounds the phase counter to 2**LOG_W - 1 bits.
  localparam int LOG_W  = 3;
  localparam int TICK_N = 1 << LOG_W;

  typedef logic [LOG_W-1:0] rate_log2_t;

  // Strobes handed from control to datapath.
  typedef struct packed {
    rate_log2_t divLog2;  // active period exponent
    logic       outGate;  // clock output may run this cycle
    logic       muxReq;   // pin owned by clock output
  } presc_strobe_t;

  localparam rate_log2_t NORMAL_LOG2    = 3'd1;
  localparam rate_log2_t SLOW_BASE_LOG2 = 3'd2;

  // Slow codes are bit-reversed: 00->/4, 10->/8, 01->/16, 11->/32.
  function automatic rate_log2_t decodeRate(input logic slowSel, input logic [1:0] rateCode);
    rate_log2_t r;
    if (!slowSel) r = NORMAL_LOG2;
    else          r = SLOW_BASE_LOG2 + {1'b0, rateCode[0], rateCode[1]};
    return r;
  endfunction

endpackage

// File: rtl/cpu_presc_ctrl.sv
module cpu_presc_ctrl
  import cpu_presc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowSel,
  input  logic [1:0]        rateCode,
  input  logic              clkOutEn,
  input  logic              haltActive,
  input  logic [TICK_N-1:0] tickVec,
  output presc_strobe_t     strobe
);

  localparam rate_log2_t MAX_LOG2 = rate_log2_t'(CNT_W);

  rate_log2_t reqLog2Raw;
  rate_log2_t reqLog2;
  rate_log2_t activeLog2;
  rate_log2_t spanLog2;
  logic       atBoundary;

  always_comb begin
    reqLog2Raw = decodeRate(slowSel, rateCode);
    reqLog2    = (reqLog2Raw > MAX_LOG2) ? MAX_LOG2 : reqLog2Raw;
    // Switch only where both the old and the new period end together.
    spanLog2   = (reqLog2 > activeLog2) ? reqLog2 : activeLog2;
    atBoundary = tickVec[spanLog2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeLog2 <= NORMAL_LOG2;
    end else if (atBoundary && (reqLog2 != activeLog2)) begin
      activeLog2 <= reqLog2;
    end
  end

  assign strobe = '{divLog2: activeLog2,
                    outGate: clkOutEn & ~haltActive,
                    muxReq:  clkOutEn};

  // R5: a new period is adopted only on a cycle that also ended a new-period interval.
  p_switch_on_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (activeLog2 != $past(activeLog2)) |-> $past(tickVec[activeLog2]));

endmodule

// File: rtl/cpu_presc_dpath.sv
module cpu_presc_dpath
  import cpu_presc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  presc_strobe_t     strobe,
  output logic [TICK_N-1:0] tickVec,
  output logic              cpuEn,
  output logic              clkOut,
  output logic              pinMuxSel
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else       phaseCnt <= phaseCnt + CNT_ONE;
  end

  // tickVec[k] marks the last cycle of a 2**k period on the shared counter.
  for (genvar i = 0; i < TICK_N; i++) begin : g_tick
    if (i == 0) begin : g_always
      assign tickVec[i] = 1'b1;
    end else if (i <= CNT_W) begin : g_cmp
      assign tickVec[i] = &phaseCnt[i-1:0];
    end else begin : g_clamp
      assign tickVec[i] = &phaseCnt;
    end
  end

  assign cpuEn = tickVec[strobe.divLog2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkOut    <= 1'b0;
      pinMuxSel <= 1'b0;
    end else begin
      clkOut    <= strobe.outGate ? ~phaseCnt[0] : 1'b0;
      pinMuxSel <= strobe.muxReq;
    end
  end

  // R2: enable pulses never occur on adjacent cycles.
  p_min_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |=> !cpuEn);

  // R6: with the output gated on for two edges, it toggles.
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.outGate) && $past(strobe.outGate, 2)) |-> (clkOut != $past(clkOut)));

endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler
  import cpu_presc_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowSel,
  input  logic [1:0] rateCode,
  input  logic       clkOutEn,
  input  logic       haltActive,
  output logic       cpuEn,
  output logic       clkOut,
  output logic       pinMuxSel
);

  presc_strobe_t     strobe;
  logic [TICK_N-1:0] tickVec;

  cpu_presc_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .slowSel   (slowSel),
    .rateCode  (rateCode),
    .clkOutEn  (clkOutEn),
    .haltActive(haltActive),
    .tickVec   (tickVec),
    .strobe    (strobe)
  );

  cpu_presc_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tickVec  (tickVec),
    .cpuEn    (cpuEn),
    .clkOut   (clkOut),
    .pinMuxSel(pinMuxSel)
  );

  // R7: active-halt silences the clock output on the next cycle.
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    haltActive |=> !clkOut);

  // R8: the pin-mux select tracks the enable bit one edge late.
  p_mux_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pinMuxSel == $past(clkOutEn)));

endmodule

// File: tb/cpu_clk_prescaler_tb_top.sv
module cpu_clk_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slowSel = 1'b0;
  logic [1:0] rateCode = 2'b00;
  logic       clkOutEn = 1'b0;
  logic       haltActive = 1'b0;
  logic       cpuEn, clkOut, pinMuxSel;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu_clk_prescaler dut_i (
    .clk(clk), .rstN(rstN), .slowSel(slowSel), .rateCode(rateCode),
    .clkOutEn(clkOutEn), .haltActive(haltActive),
    .cpuEn(cpuEn), .clkOut(clkOut), .pinMuxSel(pinMuxSel)
  );

  // Requested period from R3/R4.
  function automatic int reqPeriod(input bit slow, input bit [1:0] code);
    if (!slow) return 2;
    case (code)
      2'b00:   return 4;
      2'b10:   return 8;
      2'b01:   return 16;
      default: return 32;
    endcase
  endfunction

  // Reference model driven by edge counting.
  int mCnt = 0;
  int mN = 2;
  bit mClk = 0;
  bit mMux = 0;
  bit mHaltPrev = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mN = 2; mClk = 0; mMux = 0; mHaltPrev = 0;
    end else begin
      int rq;
      int span;
      rq = reqPeriod(slowSel, rateCode);
      span = (rq > mN) ? rq : mN;
      if ((mCnt % span) == span - 1) mN = rq;
      mClk = (clkOutEn && !haltActive) ? ((mCnt + 1) % 2 == 1) : 1'b0;
      mCnt = (mCnt + 1) % 32;
      mMux = clkOutEn;
      mHaltPrev = haltActive;
    end
  end

  task automatic check1(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit expCpu;
      string tCpu, tClk;
      expCpu = ((mCnt % mN) == mN - 1);
      if (!rstN)                                      tCpu = "R1 cpuEn";
      else if (mN != reqPeriod(slowSel, rateCode))    tCpu = "R5 cpuEn";
      else if (mHaltPrev)                             tCpu = "R7 cpuEn under halt";
      else if (!slowSel)                              tCpu = "R2,R3 cpuEn";
      else                                            tCpu = "R2,R4 cpuEn";
      tClk = !rstN ? "R1 clkOut" : (mHaltPrev ? "R7 clkOut" : "R6 clkOut");
      check1(cpuEn == expCpu, tCpu, cpuEn, expCpu);
      check1(clkOut == mClk, tClk, clkOut, mClk);
      check1(pinMuxSel == mMux, rstN ? "R8 pinMuxSel" : "R1 pinMuxSel", pinMuxSel, mMux);
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // idx 0: normal mode (rateCode set to junk), idx 1..4: slow codes 00,10,01,11.
  task automatic applySetting(input int idx, input bit [1:0] junk);
    if (idx == 0) begin
      slowSel = 1'b0; rateCode = junk;
    end else begin
      slowSel = 1'b1;
      case (idx)
        1: rateCode = 2'b00;
        2: rateCode = 2'b10;
        3: rateCode = 2'b01;
        default: rateCode = 2'b11;
      endcase
    end
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(10);
    // Sweep every ordered pair of settings at several phases (R2-R8).
    for (int a = 0; a < 5; a++) begin
      for (int b = 0; b < 5; b++) begin
        for (int ph = 0; ph < 3; ph++) begin
          applySetting(a, 2'(ph + 1));
          clkOutEn = ((a + ph) % 3) != 0;
          haltActive = ((a + b + ph) % 4) == 1;
          waitCyc(40 + ph * 3 + b);
          applySetting(b, 2'(ph));
          clkOutEn = ((b + ph) % 2) == 0;
          waitCyc(5);
          haltActive = ((a * b + ph) % 3) == 0;
          waitCyc(65);
        end
      end
    end
    // Halt pulses with output enabled (R7, R8).
    applySetting(2, 2'b00);
    clkOutEn = 1'b1;
    for (int k = 0; k < 20; k++) begin
      haltActive = k[0];
      waitCyc(1 + (k % 3));
    end
    // Reset mid-run (R1).
    applySetting(4, 2'b00);
    waitCyc(7);
    rstN = 1'b0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(70);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule